// File: doc/BRIEF.md
# Extended Parallel Port Control Register File

This block holds the software-visible control state of an extended-capability parallel port. It holds two read-only configuration registers and one read/write control register, and it turns a handful of live port conditions into a single interrupt pulse and a DMA run permission. The FIFO storage and the port handshake engines are outside the block. They supply the FIFO threshold event and the DMA terminal count, and they consume the mode field and the DMA run signal.

The register bus is a plain single-cycle interface. A write is taken on any rising edge where `bus_wr` is high. Read data is combinational from `bus_addr`, so there is no read strobe and no read side effect. The block has no streaming data path, so it has no valid/ready handshake and applies no back-pressure. The fault input is asynchronous to `clk` and passes through a synchronizer before edge detection.

The control register holds the mode field and three control bits. The first bit, `err_mask`, masks the fault interrupt. The second, `dma_on`, enables DMA. The third, `svc_hold`, is a hold bit. Hardware sets `svc_hold` when a service interrupt occurs, and software must clear it to re-arm. While it is set, both DMA and the service interrupts are blocked.

Top module: `ppx_ctrl_regs`

## Requirements
- R1: A read at offset BASE+0 returns 8'h10, and writes to that offset change nothing that can be read.
- R2: A read at offset BASE+1 returns bit 7 = 0, bit 6 = the current level of `irq_level`, and bits 5:0 = 0. Writes to that offset are ignored.
- R3: The control register at BASE+2 stores the mode in bits 7:5, `err_mask` in bit 4, `dma_on` in bit 3 and `svc_hold` in bit 2. Bits 1:0 read as 0. Output `mode` always equals bits 7:5.
- R4: The fault line is synchronized by two flops. A high-to-low transition of `fault_n` makes `irq_pulse` high for one cycle after the third rising edge that samples the low level, provided `err_mask` is 0 on the edge before. When `err_mask` is 1, the transition gives no pulse.
- R5: A control write that changes `err_mask` from 1 to 0 while the synchronized fault is low produces an `irq_pulse` on the next cycle.
- R6: `dma_run` is 1 exactly when `dma_on` is 1 and `svc_hold` is 0.
- R7: When `svc_hold` is 0, a service event sets `svc_hold` to 1 and pulses `irq_pulse` on the next cycle. While `svc_hold` is 1, further events give no pulse until software writes bit 2 as 0. A service event in the same cycle as a control write wins over the written bit 2.
- R8: Writing bit 2 as 1 never by itself produces an `irq_pulse`.
- R9: With `dma_on` = 1, the service event is `dma_tc`. With `dma_on` = 0, the service event is `fifo_thr_evt`.
- R10: After reset, the control register reads 8'h04, `mode` is 0, `dma_run` is 0 and `irq_pulse` is 0.
- R11: A read at any address outside the three offsets returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| fault_n | input | 1 | Asynchronous fault line, active low |
| irq_level | input | 1 | Current level of the interrupt-request line |
| fifo_thr_evt | input | 1 | FIFO threshold reached, one cycle per event |
| dma_tc | input | 1 | DMA terminal count |
| mode | output | 3 | Port mode field |
| dma_run | output | 1 | DMA permitted |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench uses the default parameters: an 11-bit address, base 400h and two synchronizer stages. With these values, the three live offsets and the unmapped addresses on either side of them can all be reached. The fault-edge latency is short enough that a fault edge can be made to land in the same cycle as a control write. A long random phase drives writes, fault edges, threshold events and terminal counts at once. This exercises the priority of a hardware set of `svc_hold` over a software write, and the unlock case of a write that unmasks the fault interrupt.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  typedef struct packed {
    logic [2:0] mode;
    logic       err_mask;
    logic       dma_on;
    logic       svc_hold;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{mode: 3'b000, err_mask: 1'b0, dma_on: 1'b0, svc_hold: 1'b1};
  localparam logic [7:0] CFGA_VAL = 8'h10;

  function automatic logic [7:0] ctrl_byte(ctrl_t c);
    return {c.mode, c.err_mask, c.dma_on, c.svc_hold, 2'b00};
  endfunction
endpackage

// File: rtl/ppx_fault_edge.sv
module ppx_fault_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  output logic flt_sync,
  output logic flt_fall
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[LEN-2:0], fault_n};
  end

  assign flt_sync = chain[STAGES-1];
  assign flt_fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/ppx_svc_gate.sv
module ppx_svc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_hold,
  input  logic dma_on,
  input  logic fifo_evt,
  input  logic tc_evt,
  output logic svc_hold,
  output logic svc_fire,
  output logic dma_run
);
  logic hold_q;

  assign svc_fire = ~hold_q & (dma_on ? tc_evt : fifo_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b1;
    else if (svc_fire) hold_q <= 1'b1;
    else if (wr_ctrl)  hold_q <= wr_hold;
  end

  assign svc_hold = hold_q;
  assign dma_run  = dma_on & ~hold_q;

  // R7
  svc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> svc_hold);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_hold && !(wr_ctrl && !wr_hold)) |=> svc_hold);
endmodule

// File: rtl/ppx_ctrl_regs.sv
module ppx_ctrl_regs
  import ppx_pkg::*;
#(
  parameter int              ADDR_W      = 11,
  parameter logic [ADDR_W-1:0] BASE      = 11'h400,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              fault_n,
  input  logic              irq_level,
  input  logic              fifo_thr_evt,
  input  logic              dma_tc,
  output logic [2:0]        mode,
  output logic              dma_run,
  output logic              irq_pulse
);
  localparam logic [ADDR_W-1:0] OFS_A = BASE;
  localparam logic [ADDR_W-1:0] OFS_B = BASE + 1'b1;
  localparam logic [ADDR_W-1:0] OFS_C = BASE + 2'd2;

  logic sel_a, sel_b, sel_c, wr_c;
  assign sel_a = (bus_addr == OFS_A);
  assign sel_b = (bus_addr == OFS_B);
  assign sel_c = (bus_addr == OFS_C);
  assign wr_c  = bus_wr & sel_c;

  logic [2:0] mode_q;
  logic       mask_q, dma_q;
  logic       svc_hold, svc_fire;
  logic       flt_sync, flt_fall;
  logic       err_evt, irq_q;
  ctrl_t      ctrl_view;

  ppx_fault_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_n  (fault_n),
    .flt_sync (flt_sync),
    .flt_fall (flt_fall)
  );

  ppx_svc_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_c),
    .wr_hold  (bus_wdata[2]),
    .dma_on   (dma_q),
    .fifo_evt (fifo_thr_evt),
    .tc_evt   (dma_tc),
    .svc_hold (svc_hold),
    .svc_fire (svc_fire),
    .dma_run  (dma_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CTRL_RST.mode;
      mask_q <= CTRL_RST.err_mask;
      dma_q  <= CTRL_RST.dma_on;
    end else if (wr_c) begin
      mode_q <= bus_wdata[7:5];
      mask_q <= bus_wdata[4];
      dma_q  <= bus_wdata[3];
    end
  end

  // fault edge while unmasked, or unmasking while the fault is already low
  assign err_evt = (flt_fall & ~mask_q)
                 | (wr_c & mask_q & ~bus_wdata[4] & ~flt_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= err_evt | svc_fire;
  end

  assign ctrl_view = '{mode: mode_q, err_mask: mask_q, dma_on: dma_q, svc_hold: svc_hold};

  always_comb begin
    if (sel_a)      bus_rdata = CFGA_VAL;
    else if (sel_b) bus_rdata = {1'b0, irq_level, 6'b0};
    else if (sel_c) bus_rdata = ctrl_byte(ctrl_view);
    else            bus_rdata = 8'h00;
  end

  assign mode      = mode_q;
  assign irq_pulse = irq_q;

  // R4
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_fall && !mask_q) |=> irq_pulse);

  // R5
  unmask_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && mask_q && !bus_wdata[4] && !flt_sync) |=> irq_pulse);

  // R6
  hold_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && bus_wdata[2]) |=> !dma_run);

  // R9
  tc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_run && dma_tc) |=> (irq_pulse && svc_hold));

  // R3
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> (mode == $past(bus_wdata[7:5])));
endmodule

// File: tb/ppx_ctrl_regs_bench.sv
`timescale 1ns/100ps
module ppx_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = 11'h400;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        fault_n = 1'b1;
  logic        irq_level = 1'b0;
  logic        fifo_thr_evt = 1'b0;
  logic        dma_tc = 1'b0;
  logic [2:0]  mode;
  logic        dma_run;
  logic        irq_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  ppx_ctrl_regs u_ppx_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_n(fault_n),
    .irq_level(irq_level), .fifo_thr_evt(fifo_thr_evt), .dma_tc(dma_tc),
    .mode(mode), .dma_run(dma_run), .irq_pulse(irq_pulse)
  );

  // behavioural reference model
  bit       m_hist[$] = '{1, 1, 1};
  bit [2:0] m_mode = 0;
  bit       m_mask = 0, m_dma = 0, m_hold = 1, m_irq = 0;

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_hist = '{1, 1, 1};
      m_mode = 0; m_mask = 0; m_dma = 0; m_hold = 1; m_irq = 0;
    end else begin
      bit wr, fall, err, trig;
      wr   = bus_wr && (bus_addr == 11'h402);
      fall = m_hist[2] && !m_hist[1];
      err  = (fall && !m_mask) || (wr && m_mask && !bus_wdata[4] && !m_hist[1]);
      trig = !m_hold && (m_dma ? dma_tc : fifo_thr_evt);
      m_irq = err || trig;
      if (trig)    m_hold = 1;
      else if (wr) m_hold = bus_wdata[2];
      if (wr) begin
        m_mode = bus_wdata[7:5];
        m_mask = bus_wdata[4];
        m_dma  = bus_wdata[3];
      end
      m_hist.push_front(fault_n);
      void'(m_hist.pop_back());
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      logic [7:0] exp_rd;
      string rtag;
      if (bus_addr == 11'h400)      begin exp_rd = 8'h10; rtag = "R1"; end
      else if (bus_addr == 11'h401) begin exp_rd = {1'b0, irq_level, 6'b0}; rtag = "R2"; end
      else if (bus_addr == 11'h402) begin exp_rd = {m_mode, m_mask, m_dma, m_hold, 2'b00}; rtag = "R3"; end
      else                          begin exp_rd = 8'h00; rtag = "R11"; end
      if (!rst_n) begin
        check("R10", "ctrl read", bus_rdata, 8'h04);
        check("R10", "irq", irq_pulse, 0);
      end
      check(rtag, "rdata", bus_rdata, exp_rd);
      check("R3", "mode", mode, m_mode);
      check("R6", "dma_run", dma_run, m_dma && !m_hold);
      check("R4 R5 R7 R8 R9", "irq_pulse", irq_pulse, m_irq);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    step();
    bus_wr = 0; bus_addr = 11'h402;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bus_addr = 11'h402;
    step(4);                               // R10 reset state
    rst_n = 1; step(2);
    // R1 R2 R11 reads and ignored writes
    bus_addr = 11'h400; step();
    wr(11'h400, 8'hFF); bus_addr = 11'h400; step();
    bus_addr = 11'h401; irq_level = 1; step(); irq_level = 0; step();
    wr(11'h401, 8'hFF); bus_addr = 11'h401; irq_level = 1; step();
    bus_addr = 11'h403; step(); bus_addr = 11'h3FF; step(); bus_addr = 11'h000; step();
    bus_addr = 11'h402;
    // R3 mode field values
    wr(11'h402, 8'hA4); step(); wr(11'h402, 8'hE0); step();
    // R4 fault edge, unmasked
    fault_n = 0; step(6); fault_n = 1; step(4);
    // R4 masked edge, then R5 unmask while low
    wr(11'h402, 8'hF0); fault_n = 0; step(6);
    wr(11'h402, 8'hE0); step(3); fault_n = 1; step(4);
    // R7 R9 threshold path with dma_on=0
    fifo_thr_evt = 1; step(); fifo_thr_evt = 0; step(2);
    fifo_thr_evt = 1; step(); fifo_thr_evt = 0; step(2);
    wr(11'h402, 8'hE0); step(2);
    // R6 R9 terminal count path
    wr(11'h402, 8'hE8); step(2);
    fifo_thr_evt = 1; step(); fifo_thr_evt = 0; step();
    dma_tc = 1; step(); dma_tc = 0; step(3);
    // R8 write hold=1 gives no pulse
    wr(11'h402, 8'hE8); step(); wr(11'h402, 8'hEC); step(3);
    // mixed random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      fault_n      = ($urandom_range(0, 9) != 0) ? fault_n : ~fault_n;
      irq_level    = $urandom_range(0, 1);
      fifo_thr_evt = ($urandom_range(0, 5) == 0);
      dma_tc       = ($urandom_range(0, 5) == 0);
      bus_addr     = 11'h3FE + 11'($urandom_range(0, 6));
      bus_wr       = (r < 20);
      if (r < 12) bus_addr = 11'h402;
      bus_wdata    = 8'($urandom_range(0, 255));
      step();
    end
    bus_wr = 0; fifo_thr_evt = 0; dma_tc = 0;
    step(4);
    finish_run();
  end
endmodule